// File: doc/BRIEF.md
# Four-Bank Row-Cache Access Controller

This block sits in front of a DRAM array that is split into four independent banks. Each bank keeps one SRAM row register holding a complete row, plus a stored tag for the row that register currently holds. Each access carries a full row address and a column. Two row-address bits pick the bank. The other row bits are compared with that bank's tag.

A read that matches the tag is answered from the row register on the next cycle, and the DRAM is not touched. A read that misses stalls the requester while the whole row is copied from the DRAM model into that bank's row register in one wide transfer. The tag is then updated and the word is returned a fixed number of cycles after the request.

Writes never stall. They are held for one cycle in a posting register and then committed to the DRAM. If the written row is the one cached in its bank, the row register word is updated in the same cycle, so the cache stays coherent. A refresh request input steps an internal row counter through the array. Refresh runs alongside cache hits and waits only while a miss fill is in progress.

Top module: `bank_row_cache`

## Requirements
- R1: After reset, `acc_ready` is 1, `rd_valid` and `ref_fire` are 0, and every bank's tag is invalid, so the first read that reaches any bank is a miss (`rd_hit`=0).
- R2: Row-address bits [BANK_LSB+1:BANK_LSB] select the bank, with BANK_LSB = ROW_W-3 (bits 3:2 for the default 5-bit row). The tag is the top row bit concatenated with bits [BANK_LSB-1:0]. Two rows of one bank that differ in tag displace each other.
- R3: A read hit gives `rd_valid`=1 and `rd_hit`=1 exactly one cycle after the request is accepted, with the word taken from the bank's row register.
- R4: A read miss holds `acc_ready` low for FILL_LAT-1 cycles. It gives `rd_valid`=1 with `rd_hit`=0 exactly FILL_LAT cycles after the request (default 3), with the DRAM word, and sets the tag so that a repeated read of that row is a hit.
- R5: Reads to the cached row may be issued in consecutive cycles, and each one returns one word per cycle.
- R6: A fill into one bank leaves the row registers and tags of the other banks unchanged.
- R7: A write is accepted in any cycle where `acc_ready` is 1 and produces no `rd_valid`. When its row is the one cached in its bank, a later hit read of that word returns the written data.
- R8: A write to a row that is not cached updates only the DRAM. The bank's row register keeps its old contents, and a later miss read of the written row returns the new data.
- R9: The DRAM word at address row*2^COL_W + col starts, after reset, at (37*address + 11) mod 2^DW.
- R10: Each `ref_req` pulse, given while no refresh is waiting, produces exactly one single-cycle `ref_fire`. The `ref_row` values of successive pulses run 0, 1, 2, ... and wrap at 2^ROW_W.
- R11: `ref_fire` is never asserted while a miss fill is in progress (`acc_ready`=0). A refresh requested during a fill fires after the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request, taken when `acc_ready` is 1 |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_row | input | ROW_W | Row address (bank bits inside) |
| acc_col | input | COL_W | Column within the row |
| acc_wdata | input | DW | Write data |
| acc_ready | output | 1 | Low while a miss fill is in progress |
| rd_valid | output | 1 | Read data strobe |
| rd_hit | output | 1 | 1 when the returned read was a hit |
| rd_data | output | DW | Returned read word |
| ref_req | input | 1 | Refresh request pulse |
| ref_fire | output | 1 | A refresh step is done this cycle |
| ref_row | output | ROW_W | Row refreshed when `ref_fire` is 1 |

## Verification
The bench goes after latency first: every returned word is compared with its expected cycle. A design that answered a miss early would return stale row-register data, and one that answered late would break the one-word-per-cycle hit stream. Tag aliasing is covered by alternating two rows of the same bank and by touching all four banks. A bank-select or tag slice taken from the wrong bits would turn the expected misses into hits, or the reverse. Writes to both cached and uncached rows are followed by reads, which exposes a missing write-through or a row register corrupted by a write to a different row. A refresh requested in the middle of a fill shows whether the design lets refresh fire while the fill holds the DRAM.

// File: rtl/rcache_pkg.sv
package rcache_pkg;
    localparam int DEF_DW    = 16;
    localparam int DEF_ROW_W = 5;
    localparam int DEF_COL_W = 4;
    localparam int DEF_FILL  = 3;

    // power-up content pattern of the DRAM model
    function automatic logic [63:0] seed_word(input int unsigned addr);
        return 64'(addr) * 64'd37 + 64'd11;
    endfunction
endpackage

// File: rtl/rcache_dram.sv
module rcache_dram
    import rcache_pkg::*;
#(
    parameter int DW    = DEF_DW,
    parameter int ROW_W = DEF_ROW_W,
    parameter int COL_W = DEF_COL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ROW_W+COL_W-1:0]        wr_addr,
    input  logic [DW-1:0]                 wr_data,
    input  logic [ROW_W-1:0]              line_row,
    output logic [(1<<COL_W)-1:0][DW-1:0] line_data
);
    localparam int COLS  = 1 << COL_W;
    localparam int DEPTH = 1 << (ROW_W + COL_W);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(seed_word(int'(i)));
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // full-row wide read used by the fill path
    always_comb begin
        for (int c = 0; c < COLS; c++) line_data[c] = mem_q[{line_row, COL_W'(c)}];
    end
endmodule

// File: rtl/rcache_rowbank.sv
module rcache_rowbank #(
    parameter int DW    = 16,
    parameter int COL_W = 4,
    parameter int NB    = 4,
    localparam int BW   = $clog2(NB),
    localparam int COLS = 1 << COL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [BW-1:0]             wr_bank,
    input  logic [COL_W-1:0]          wr_col,
    input  logic [DW-1:0]             wr_data,
    input  logic                      ld_en,
    input  logic [BW-1:0]             ld_bank,
    input  logic [COLS-1:0][DW-1:0]   ld_line,
    input  logic [BW-1:0]             rd_bank,
    input  logic [COL_W-1:0]          rd_col,
    output logic [DW-1:0]             rd_word
);
    logic [COLS-1:0][DW-1:0] lines [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [COLS-1:0][DW-1:0] line_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= '0;
            end else if (ld_en && ld_bank == BW'(b)) begin
                line_q <= ld_line;
            end else if (wr_en && wr_bank == BW'(b)) begin
                line_q[wr_col] <= wr_data;
            end
        end
        assign lines[b] = line_q;
    end

    assign rd_word = lines[rd_bank][rd_col];

    // R6
    fill_vs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !wr_en);
endmodule

// File: rtl/rcache_refresh.sv
module rcache_refresh #(
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             hold,
    output logic             fire,
    output logic [ROW_W-1:0] row
);
    logic             pend_d, pend_q;
    logic [ROW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire   = pend_q && !hold;
        pend_d = req || (pend_q && !fire);
        cnt_d  = fire ? cnt_q + ROW_W'(1) : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            pend_q <= pend_d;
            cnt_q  <= cnt_d;
        end
    end

    assign row = cnt_q;

    // R10
    ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!pend_q || $past(req)));
endmodule

// File: rtl/bank_row_cache.sv
module bank_row_cache
    import rcache_pkg::*;
#(
    parameter int DW       = DEF_DW,
    parameter int ROW_W    = DEF_ROW_W,
    parameter int COL_W    = DEF_COL_W,
    parameter int FILL_LAT = DEF_FILL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_we,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    input  logic [DW-1:0]    acc_wdata,
    output logic             acc_ready,
    output logic             rd_valid,
    output logic             rd_hit,
    output logic [DW-1:0]    rd_data,
    input  logic             ref_req,
    output logic             ref_fire,
    output logic [ROW_W-1:0] ref_row
);
    localparam int NB       = 4;
    localparam int BW       = 2;
    localparam int BANK_LSB = ROW_W - 3;
    localparam int TAG_W    = ROW_W - BW;
    localparam int COLS     = 1 << COL_W;
    localparam int AW       = ROW_W + COL_W;
    localparam int FILL_EFF = (FILL_LAT < 2) ? 2 : FILL_LAT;
    localparam int FCW      = $clog2(FILL_EFF);

    typedef struct packed {
        logic                        busy;
        logic [FCW-1:0]              fcnt;
        logic [BW-1:0]               fbank;
        logic [ROW_W-1:0]            frow;
        logic [COL_W-1:0]            fcol;
        logic [NB-1:0]               tval;
        logic [NB-1:0][TAG_W-1:0]    tags;
        logic                        rd_valid;
        logic                        rd_hit;
        logic [DW-1:0]               rd_data;
        logic                        post_v;
        logic [AW-1:0]               post_a;
        logic [DW-1:0]               post_d;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [TAG_W-1:0] tag_of(input logic [ROW_W-1:0] r);
        return {r[ROW_W-1], r[BANK_LSB-1:0]};
    endfunction

    logic                    acc_fire, a_hit, fill_done;
    logic [BW-1:0]           a_bank;
    logic                    rb_wr_en, rb_ld_en;
    logic [DW-1:0]           rb_word;
    logic [COLS-1:0][DW-1:0] dram_line;

    always_comb begin
        acc_fire  = acc_valid && !st_q.busy;
        a_bank    = acc_row[BANK_LSB +: BW];
        a_hit     = st_q.tval[a_bank] && (st_q.tags[a_bank] == tag_of(acc_row));
        fill_done = st_q.busy && (st_q.fcnt == '0);
        rb_wr_en  = 1'b0;
        rb_ld_en  = 1'b0;

        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.rd_hit   = 1'b0;
        st_d.post_v   = 1'b0;

        if (fill_done) begin
            st_d.busy              = 1'b0;
            st_d.tval[st_q.fbank]  = 1'b1;
            st_d.tags[st_q.fbank]  = tag_of(st_q.frow);
            st_d.rd_valid          = 1'b1;
            st_d.rd_data           = dram_line[st_q.fcol];
            rb_ld_en               = 1'b1;
        end else if (st_q.busy) begin
            st_d.fcnt = st_q.fcnt - FCW'(1);
        end

        if (acc_fire) begin
            if (acc_we) begin
                st_d.post_v = 1'b1;
                st_d.post_a = {acc_row, acc_col};
                st_d.post_d = acc_wdata;
                rb_wr_en    = a_hit;
            end else if (a_hit) begin
                st_d.rd_valid = 1'b1;
                st_d.rd_hit   = 1'b1;
                st_d.rd_data  = rb_word;
            end else begin
                st_d.busy  = 1'b1;
                st_d.fcnt  = FCW'(FILL_EFF - 2);
                st_d.fbank = a_bank;
                st_d.frow  = acc_row;
                st_d.fcol  = acc_col;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rcache_dram #(.DW(DW), .ROW_W(ROW_W), .COL_W(COL_W)) i_dram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_q.post_v),
        .wr_addr   (st_q.post_a),
        .wr_data   (st_q.post_d),
        .line_row  (st_q.frow),
        .line_data (dram_line)
    );

    rcache_rowbank #(.DW(DW), .COL_W(COL_W), .NB(NB)) i_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rb_wr_en),
        .wr_bank (a_bank),
        .wr_col  (acc_col),
        .wr_data (acc_wdata),
        .ld_en   (rb_ld_en),
        .ld_bank (st_q.fbank),
        .ld_line (dram_line),
        .rd_bank (a_bank),
        .rd_col  (acc_col),
        .rd_word (rb_word)
    );

    rcache_refresh #(.ROW_W(ROW_W)) i_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ref_req),
        .hold  (st_q.busy),
        .fire  (ref_fire),
        .row   (ref_row)
    );

    assign acc_ready = !st_q.busy;
    assign rd_valid  = st_q.rd_valid;
    assign rd_hit    = st_q.rd_hit;
    assign rd_data   = st_q.rd_data;

    // R3
    hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd_valid && st_q.rd_hit) |-> $past(acc_valid && !acc_we && !st_q.busy));
    // R4
    miss_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(acc_valid && !acc_we));
    // R4
    miss_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> (st_q.rd_valid && !st_q.rd_hit));
    // R11
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fire |-> !st_q.busy);
endmodule

// File: tb/test_bank_row_cache.sv
module test_bank_row_cache;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16, ROW_W = 5, COL_W = 4, FILL = 3;
    localparam int DEPTH = 1 << (ROW_W + COL_W);

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_we = 1'b0, ref_req = 1'b0;
    logic [ROW_W-1:0] acc_row = '0;
    logic [COL_W-1:0] acc_col = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic acc_ready, rd_valid, rd_hit, ref_fire;
    logic [DW-1:0] rd_data;
    logic [ROW_W-1:0] ref_row;

    bank_row_cache #(.DW(DW), .ROW_W(ROW_W), .COL_W(COL_W), .FILL_LAT(FILL)) i_bank_row_cache (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_row(acc_row), .acc_col(acc_col), .acc_wdata(acc_wdata),
        .acc_ready(acc_ready), .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_data(rd_data),
        .ref_req(ref_req), .ref_fire(ref_fire), .ref_row(ref_row)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [DW-1:0] d; logic h; int c; string tag; } exp_t;
    exp_t sb[$];

    int cyc = 0, errors = 0, checks = 0;
    int ref_sent = 0, ref_seen = 0;
    logic [ROW_W-1:0] exp_ref = '0;
    logic [DW-1:0] mem_m [DEPTH];
    logic [DW-1:0] line_m [4][16];
    int tag_m [4];
    bit tv_m [4];
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int bank_of(input int r); return (r >> 2) & 3; endfunction
    function automatic int tag_of(input int r); return ((r >> 4) << 2) | (r & 3); endfunction

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic access(input bit we, input int row, input int col,
                          input logic [DW-1:0] wd, input string req);
        int b;
        exp_t e;
        while (!acc_ready) @(negedge clk);
        acc_valid = 1'b1; acc_we = we;
        acc_row = ROW_W'(row); acc_col = COL_W'(col); acc_wdata = wd;
        b = bank_of(row);
        if (we) begin
            mem_m[row*16 + col] = wd;
            if (tv_m[b] && tag_m[b] == tag_of(row)) line_m[b][col] = wd;
        end else if (tv_m[b] && tag_m[b] == tag_of(row)) begin
            e.d = line_m[b][col]; e.h = 1'b1; e.c = cyc + 1; e.tag = req;
            sb.push_back(e);
        end else begin
            for (int k = 0; k < 16; k++) line_m[b][k] = mem_m[row*16 + k];
            tv_m[b] = 1; tag_m[b] = tag_of(row);
            e.d = line_m[b][col]; e.h = 1'b0; e.c = cyc + FILL; e.tag = req;
            sb.push_back(e);
        end
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b0;
    endtask

    task automatic pulse_ref();
        ref_req = 1'b1; ref_sent++;
        @(negedge clk);
        ref_req = 1'b0;
    endtask

    // monitor: scoreboard pops and refresh tracking
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R3", $sformatf("unexpected rd_valid data=%h", rd_data));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rd_data == e.d && rd_hit == e.h && cyc == e.c, e.tag,
                        $sformatf("got data=%h hit=%0d cyc=%0d exp data=%h hit=%0d cyc=%0d",
                                  rd_data, rd_hit, cyc, e.d, e.h, e.c));
                end
            end
            if (ref_fire) begin
                ref_seen++;
                chk(ref_row == exp_ref, "R10",
                    $sformatf("ref_row got %0d exp %0d", ref_row, exp_ref));
                chk(acc_ready, "R11", $sformatf("ref_fire during fill, acc_ready got %0d exp 1", acc_ready));
                exp_ref = exp_ref + 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) mem_m[a] = DW'(37*a + 11); // R9
        for (int b = 0; b < 4; b++) tv_m[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(acc_ready == 1'b1, "R1", $sformatf("acc_ready got %0d exp 1", acc_ready));
        chk(rd_valid == 1'b0, "R1", $sformatf("rd_valid got %0d exp 0", rd_valid));
        chk(ref_fire == 1'b0, "R1", $sformatf("ref_fire got %0d exp 0", ref_fire));

        // R1 R4 R9: first read of bank 0 misses
        access(0, 0, 3, '0, "R4");
        access(0, 0, 3, '0, "R3");
        // R5 hit stream
        for (int c = 4; c < 10; c++) access(0, 0, c, '0, "R5");
        // R2 other banks first access misses
        access(0, 4, 1, '0, "R2");
        access(0, 8, 2, '0, "R2");
        access(0, 12, 15, '0, "R2");
        // R6 bank 0 still cached
        access(0, 0, 0, '0, "R6");
        access(0, 4, 5, '0, "R6");
        // R2 same bank other tag displaces
        access(0, 1, 6, '0, "R2");
        access(0, 0, 6, '0, "R2");
        access(0, 17, 6, '0, "R2");
        access(0, 17, 7, '0, "R3");
        // R7 write-through on cached row, back-to-back
        access(1, 17, 2, 16'hBEEF, "R7");
        access(1, 17, 8, 16'h1357, "R7");
        access(0, 17, 2, '0, "R7");
        access(0, 17, 8, '0, "R7");
        // R8 write to uncached row of the same bank
        access(1, 1, 0, 16'h1234, "R8");
        access(0, 17, 0, '0, "R8");
        access(0, 1, 0, '0, "R8");
        access(0, 1, 1, '0, "R8");
        // R10 refresh while idle and interleaved with hits
        pulse_ref();
        @(negedge clk);
        pulse_ref();
        access(0, 1, 0, '0, "R10");
        pulse_ref();
        access(0, 1, 2, '0, "R10");
        // R11 refresh during a fill
        access(0, 30, 4, '0, "R11");
        pulse_ref();
        access(0, 30, 5, '0, "R11");
        access(0, 8, 2, '0, "R11");
        repeat (8) @(negedge clk);
        chk(sb.size() == 0, "R4", $sformatf("pending reads got %0d exp 0", sb.size()));
        chk(ref_seen == ref_sent, "R10",
            $sformatf("refresh count got %0d exp %0d", ref_seen, ref_sent));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule